// File: doc/BRIEF.md
# Status Flag and Branch Condition Unit

This block keeps a processor's four arithmetic status flags and answers branch-condition queries against them. When the update strobe is high, the execute stage presents the two operands of an add or subtract, the full-width result, the operation kind and the operand size (byte, word or long). The block derives carry, zero, sign and overflow at that size and stores them on the clock edge.

A separate load port writes all four flags at once, for example when saved status is restored after an exception. A 4-bit condition code selects one of sixteen tests on the stored flags: never, always, single-flag tests, signed relations and unsigned relations. The answer is a combinational true/false bit, so branch resolution in the same cycle always sees the flags as they stood before the current edge.

Top module: `status_cond_unit`

## Requirements
- R1: While `rst_n` is low, all four flags are 0 (`flags_q` = 4'b0000).
- R2: Flags change only on a rising clock edge where `upd_en` or `load_en` is high. Otherwise they hold their value, whatever the operand, result and size inputs do.
- R3: When `load_en` is high, `flags_q` takes `load_flags` on the next edge, even if `upd_en` is also high in that cycle.
- R4: The flag vector layout is bit 3 carry, bit 2 zero, bit 1 sign, bit 0 overflow, for both `load_flags` and `flags_q`. `op_size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.
- R5: For a subtract, carry is set when operand A, truncated to the size, is unsigned-less-than operand B truncated the same way (a borrow). This rule applies at every size.
- R6: For an add at 8 or 32 bits, carry is set when the truncated result is unsigned-less-than truncated operand A. For a 16-bit add, carry is bit 16 of the supplied result.
- R7: For an add, overflow is set when A and B have equal sign bits at the size and the result's sign bit differs from B's.
- R8: For a subtract, overflow is set when A and B have different sign bits at the size and the result's sign bit equals B's.
- R9: Sign is the result's top bit at the size. Zero is set when the result truncated to the size is all zeros. Bits above the size do not affect sign or zero.
- R10: Condition codes 0x0 never, 0x8 always, 0x4/0xC overflow set/clear, 0x5/0xD sign set/clear, and 0x7/0xF carry set/clear.
- R11: Signed codes: 0x1 less-than (S xor V), 0x9 its complement; 0x2 less-or-equal (Z or (S xor V)), 0xA its complement; 0x6 equal (Z), 0xE not-equal.
- R12: Unsigned codes: 0x3 lower-or-same (C or Z), 0xB its complement (greater-than).
- R13: `cc_true` is combinational from the stored flags. In the cycle of an update it reflects the flags from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Derive and store flags from the arithmetic inputs |
| is_sub | input | 1 | 1 = subtract, 0 = add |
| op_size | input | 2 | Operand size select |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| result | input | 32 | Full-width result of the operation |
| load_en | input | 1 | Direct flag load, priority over `upd_en` |
| load_flags | input | 4 | Flag value for direct load |
| cc | input | 4 | Condition code to evaluate |
| flags_q | output | 4 | Stored flags {C,Z,S,V} |
| cc_true | output | 1 | Selected condition holds |

## Verification
The assertions assume that inputs are known whenever reset is released, and that `result` is whatever the adder produced. They do not assume it matches A plus or minus B, so the flag rules are checked for any result value. The 16-bit carry rule is only meaningful when `result` carries the widened sum. The stimulus therefore always presents the true full-width sum or difference, and it places arbitrary bits above the selected size to exercise R9. All inputs change on the falling edge, so each sampled edge sees stable values.

// File: rtl/stcond_pkg.sv
package stcond_pkg;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
  } flag_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } opsize_e;

  typedef enum logic [3:0] {
    CC_NEVER  = 4'h0,
    CC_LT     = 4'h1,
    CC_LE     = 4'h2,
    CC_ULE    = 4'h3,
    CC_OVF    = 4'h4,
    CC_MINUS  = 4'h5,
    CC_EQ     = 4'h6,
    CC_CARRY  = 4'h7,
    CC_ALWAYS = 4'h8,
    CC_GE     = 4'h9,
    CC_GT     = 4'hA,
    CC_UGT    = 4'hB,
    CC_NOVF   = 4'hC,
    CC_PLUS   = 4'hD,
    CC_NE     = 4'hE,
    CC_NCARRY = 4'hF
  } cc_e;

  localparam int NUM_LANES = 3;
  localparam int NUM_CC    = 16;

endpackage

// File: rtl/flag_lane.sv
module flag_lane
  import stcond_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LANE_W     = 8,
  parameter bit WIDE_CARRY = 1'b0
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  input  logic              is_sub,
  output flag_t             lane_flags
);

  localparam int MSB = LANE_W - 1;

  logic [LANE_W-1:0] a_t, b_t, r_t;
  logic              add_carry;

  assign a_t = opnd_a[MSB:0];
  assign b_t = opnd_b[MSB:0];
  assign r_t = result[MSB:0];

  generate
    if (WIDE_CARRY) begin : g_wide
      assign add_carry = result[LANE_W];
    end else begin : g_cmp
      assign add_carry = (r_t < a_t);
    end
  endgenerate

  always_comb begin
    lane_flags.z = (r_t == '0);
    lane_flags.s = r_t[MSB];
    if (is_sub) begin
      lane_flags.c = (a_t < b_t);
      lane_flags.v = (a_t[MSB] != b_t[MSB]) && (r_t[MSB] == b_t[MSB]);
    end else begin
      lane_flags.c = add_carry;
      lane_flags.v = (a_t[MSB] == b_t[MSB]) && (r_t[MSB] != b_t[MSB]);
    end
  end

endmodule

// File: rtl/flag_store.sv
module flag_store
  import stcond_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_en,
  input  flag_t upd_flags,
  input  logic  load_en,
  input  flag_t load_flags,
  output flag_t flags_q
);

  flag_t flags_d;
  logic  flags_en;

  always_comb begin
    flags_en = load_en | upd_en;
    flags_d  = load_en ? load_flags : upd_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assert_load_priority_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (flags_q == $past(load_flags)));

  assert_hold_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !upd_en) |=> $stable(flags_q));

endmodule

// File: rtl/cond_decode.sv
module cond_decode
  import stcond_pkg::*;
(
  input  flag_t               flags,
  output logic [NUM_CC-1:0]   hits
);

  logic lt_s, le_s, ule_u;

  always_comb begin
    lt_s  = flags.s ^ flags.v;
    le_s  = flags.z | (flags.s ^ flags.v);
    ule_u = flags.c | flags.z;
    hits  = '0;
    for (int k = 0; k < NUM_CC; k++) begin
      case (cc_e'(k))
        CC_NEVER:  hits[k] = 1'b0;
        CC_LT:     hits[k] = lt_s;
        CC_LE:     hits[k] = le_s;
        CC_ULE:    hits[k] = ule_u;
        CC_OVF:    hits[k] = flags.v;
        CC_MINUS:  hits[k] = flags.s;
        CC_EQ:     hits[k] = flags.z;
        CC_CARRY:  hits[k] = flags.c;
        CC_ALWAYS: hits[k] = 1'b1;
        CC_GE:     hits[k] = ~(flags.s ^ flags.v);
        CC_GT:     hits[k] = ~(flags.z | lt_s);
        CC_UGT:    hits[k] = ~(flags.c | flags.z);
        CC_NOVF:   hits[k] = ~flags.v;
        CC_PLUS:   hits[k] = ~flags.s;
        CC_NE:     hits[k] = ~flags.z;
        CC_NCARRY: hits[k] = ~flags.c;
        default:   hits[k] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/status_cond_unit.sv
module status_cond_unit
  import stcond_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              is_sub,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  input  logic              load_en,
  input  logic [3:0]        load_flags,
  input  logic [3:0]        cc,
  output logic [3:0]        flags_q,
  output logic              cc_true
);

  localparam int LANE_WORD = 1;

  function automatic int lane_width(input int idx);
    case (idx)
      0:       return BYTE_W;
      1:       return WORD_W;
      default: return DATA_W;
    endcase
  endfunction

  flag_t               lane_flags [NUM_LANES];
  flag_t               upd_flags;
  flag_t               stored;
  logic [NUM_CC-1:0]   hits;

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      flag_lane #(
        .DATA_W    (DATA_W),
        .LANE_W    (lane_width(g)),
        .WIDE_CARRY(g == LANE_WORD)
      ) i_lane (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .is_sub    (is_sub),
        .lane_flags(lane_flags[g])
      );
    end
  endgenerate

  always_comb begin
    case (opsize_e'(op_size))
      SZ_BYTE: upd_flags = lane_flags[0];
      SZ_WORD: upd_flags = lane_flags[1];
      default: upd_flags = lane_flags[2];
    endcase
  end

  flag_store i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .upd_flags (upd_flags),
    .load_en   (load_en),
    .load_flags(flag_t'(load_flags)),
    .flags_q   (stored)
  );

  cond_decode i_decode (
    .flags(stored),
    .hits (hits)
  );

  assign flags_q = stored;
  assign cc_true = hits[cc];

  // Each code and the code eight above it are opposite tests (R10, R11, R12).
  generate
    for (genvar p = 0; p < NUM_CC / 2; p++) begin : g_pair
      assert_pair_opposite_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        hits[p] != hits[p + NUM_CC / 2]);
    end
  endgenerate

  assert_always_code_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (cc == CC_ALWAYS) |-> cc_true);

  assert_sign_byte_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !load_en && op_size == SZ_BYTE) |=> (flags_q[1] == $past(result[BYTE_W-1])));

  assert_zero_word_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !load_en && op_size == SZ_WORD && result[WORD_W-1:0] == '0) |=> flags_q[2]);

  assert_borrow_long_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !load_en && is_sub && op_size == SZ_LONG)
      |=> (flags_q[3] == ($past(opnd_a) < $past(opnd_b))));

  assert_word_carry_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !load_en && !is_sub && op_size == SZ_WORD) |=> (flags_q[3] == $past(result[WORD_W])));

endmodule

// File: tb/test_status_cond_unit.sv
module test_status_cond_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_en, is_sub, load_en;
  logic [1:0]  op_size;
  logic [31:0] opnd_a, opnd_b, result;
  logic [3:0]  load_flags, cc, flags_q;
  logic        cc_true;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  status_cond_unit i_status_cond_unit (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .is_sub(is_sub),
    .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .load_en(load_en), .load_flags(load_flags), .cc(cc),
    .flags_q(flags_q), .cc_true(cc_true)
  );

  // Vector ctrl byte: {size[1:0], sub, 1'b0, expected {C,Z,S,V}}
  localparam int NV = 13;
  localparam logic [7:0] V_CTL [NV] = '{
    8'b00_0_0_0011, 8'b00_0_0_1100, 8'b00_1_0_1010, 8'b00_1_0_0001,
    8'b01_0_0_1100, 8'b01_0_0_0011, 8'b01_1_0_0100, 8'b10_0_0_1000,
    8'b10_1_0_0001, 8'b10_1_0_1010, 8'b11_0_0_0011, 8'b00_0_0_0000,
    8'b01_1_0_1010 };
  localparam logic [31:0] V_A [NV] = '{
    32'h7F, 32'hFF, 32'h10, 32'h80, 32'hFFFF, 32'h7FFF, 32'h5, 32'hFFFFFFFF,
    32'h80000000, 32'h3, 32'h40000000, 32'hAB000012, 32'h0 };
  localparam logic [31:0] V_B [NV] = '{
    32'h01, 32'h01, 32'h20, 32'h01, 32'h0001, 32'h0001, 32'h5, 32'h2,
    32'h1, 32'h10, 32'h40000000, 32'h55000003, 32'h1 };
  localparam logic [31:0] V_R [NV] = '{
    32'h80, 32'h100, 32'hFFFFFFF0, 32'h7F, 32'h10000, 32'h8000, 32'h0, 32'h1,
    32'h7FFFFFFF, 32'hFFFFFFF3, 32'h80000000, 32'h12345615, 32'hFFFFFFFF };

  function automatic logic exp_cc(input logic [3:0] f, input int code);
    logic c, z, s, v;
    {c, z, s, v} = f;
    case (code)
      0: return 1'b0;          1: return s ^ v;
      2: return z | (s ^ v);   3: return c | z;
      4: return v;             5: return s;
      6: return z;             7: return c;
      8: return 1'b1;          9: return ~(s ^ v);
      10: return ~(z | (s ^ v)); 11: return ~(c | z);
      12: return ~v;           13: return ~s;
      14: return ~z;           default: return ~c;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    upd_en = 1'b0; load_en = 1'b0; is_sub = 1'b0; op_size = 2'd0;
    opnd_a = '0; opnd_b = '0; result = '0; load_flags = '0; cc = '0;
  endtask

  task automatic load(input logic [3:0] f);
    @(negedge clk);
    load_en = 1'b1; load_flags = f;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset flags", {28'd0, flags_q}, 32'h0);
    cc = 4'h8;
    #1 check("R10 always during reset", {31'd0, cc_true}, 32'h1);
    rst_n = 1'b1;

    // Vector table: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      upd_en  = 1'b1;
      op_size = V_CTL[i][7:6];
      is_sub  = V_CTL[i][5];
      opnd_a  = V_A[i]; opnd_b = V_B[i]; result = V_R[i];
      @(negedge clk);
      upd_en = 1'b0;
      check($sformatf("R5/R6/R7/R8/R9 vector %0d flags", i), {28'd0, flags_q}, {28'd0, V_CTL[i][3:0]});
    end

    // Condition decode over every flag value: R10 R11 R12
    for (int f = 0; f < 16; f++) begin
      load(4'(f));
      for (int k = 0; k < 16; k++) begin
        cc = 4'(k);
        #1 check($sformatf("R10/R11/R12 flags %0h code %0h", f, k),
                 {31'd0, cc_true}, {31'd0, exp_cc(4'(f), k)});
      end
    end

    // R2: no strobe, changing inputs leave flags alone
    load(4'b0101);
    @(negedge clk);
    op_size = 2'd0; is_sub = 1'b1; opnd_a = 32'h1; opnd_b = 32'h2; result = 32'hFF;
    repeat (3) @(negedge clk);
    check("R2 hold without strobe", {28'd0, flags_q}, 32'h5);

    // R3: load beats update in same cycle
    @(negedge clk);
    upd_en = 1'b1; load_en = 1'b1; load_flags = 4'b0010;
    op_size = 2'd2; is_sub = 1'b0; opnd_a = 32'hFFFFFFFF; opnd_b = 32'h1; result = 32'h0;
    @(negedge clk);
    upd_en = 1'b0; load_en = 1'b0;
    check("R3 load priority", {28'd0, flags_q}, 32'h2);

    // R13: condition shows old flags in update cycle
    load(4'b0000);
    @(negedge clk);
    cc = 4'h6; upd_en = 1'b1; op_size = 2'd0; is_sub = 1'b1;
    opnd_a = 32'h7; opnd_b = 32'h7; result = 32'h0;
    #1 check("R13 equal before edge", {31'd0, cc_true}, 32'h0);
    @(negedge clk);
    upd_en = 1'b0;
    check("R13 equal after edge", {31'd0, cc_true}, 32'h1);

    // R9: bits above byte size ignored for zero
    @(negedge clk);
    upd_en = 1'b1; op_size = 2'd0; is_sub = 1'b0;
    opnd_a = 32'h00000080; opnd_b = 32'h00000080; result = 32'h00000100;
    @(negedge clk);
    upd_en = 1'b0;
    check("R9 zero with upper bits", {28'd0, flags_q}, 32'b1101);

    // R1: asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #1 check("R1 async reset", {28'd0, flags_q}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule